// File: doc/BRIEF.md
# Supply Voltage Monitor Sequencer

This block is the digital controller that sits beside an analog supply comparator. It decides when the comparator is powered. It turns the comparator's one-bit output into a detection status. It then raises either a sticky interrupt flag or a one-cycle system reset request. The comparator output `cmp_out` is 1 when the supply is above the threshold and 0 when it is below. A sample counts as a positive detection ("hit") when `cmp_out` equals `dir`: with `dir`=0 (drop watch) a hit is `cmp_out`=0, and with `dir`=1 (rise watch) a hit is `cmp_out`=1.

Setting `en` starts monitoring. The block first holds the comparator powered through a masking window and ignores its result. It then either samples on every cycle (continuous mode) or wakes the comparator briefly at a fixed interval (intermittent mode). In intermittent mode a hit filter requires a programmable number of hits in a row before an event is raised. The action key selects a reset in place of an interrupt, but only while drops are being watched. Configuration arrives as plain ports. The analog parts and the register bus are outside the block.

Top module: `svm_seq`

## Requirements
- R1: While `en` is 0, the block is idle. From the second cycle after `en` is sampled low, `cmp_pwr` and `det_status` are 0, `rst_req` stays 0, and all internal counts restart. `irq_flag` is not cleared by disabling.
- R2: After `en` is sampled high, the block spends one idle cycle and then a 64-cycle masking window. During the window `cmp_pwr` is 1 and comparator results are ignored: `det_status` stays 0 and no event is raised.
- R3: In continuous mode (`mode`=0), `cmp_pwr` stays 1 for as long as `en` is 1 after masking. `det_status` is loaded with the hit value on every cycle, and each 0-to-1 change of `det_status` raises one event. This path never waits on the interval timer.
- R4: In intermittent mode, `cmp_pwr` pulses high for 4 cycles and the hit is loaded into `det_status` on the last of those cycles. The rising edges of `cmp_pwr` are spaced by the interval plus 4 cycles. The interval is 256, 1024 or 4096 cycles for `mode` = 1, 2 or 3.
- R5: An event drives `rst_req` only when `action` equals 4'hA and `dir` is 0. Every other event sets `irq_flag` instead, so rise watching can never cause a reset.
- R6: `rst_req` is a pulse exactly one cycle wide.
- R7: `irq_flag` stays set until a cycle with `flag_clr`=1. That cycle clears it.
- R8: In intermittent mode, an event needs N hits in a row, where `cnt_sel` 0, 1, 2 or 3 gives N = 1, 2, 4 or 8. A miss restarts the run, and after an event the next event needs another N hits.
- R9: `mode` is captured when monitoring starts. Changing it while `en` stays 1 has no effect until the next enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Low-speed clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en | input | 1 | Monitoring enable |
| mode | input | 2 | 0 continuous, 1..3 intermittent interval select |
| dir | input | 1 | 0 watch for drop, 1 watch for rise |
| cnt_sel | input | 2 | Consecutive-hit count select |
| action | input | 4 | Action key; 4'hA with dir=0 selects reset |
| cmp_out | input | 1 | Comparator output, 1 = supply above threshold |
| flag_clr | input | 1 | Write-one-to-clear pulse for irq_flag |
| cmp_pwr | output | 1 | Comparator power enable |
| det_status | output | 1 | Latest detection result |
| irq_flag | output | 1 | Sticky interrupt flag |
| rst_req | output | 1 | One-cycle system reset request |

## Verification
The bench checks that hits arriving inside the masking window leave the status and flag untouched. A design that unmasked too early would raise a spurious interrupt right after enable. It drives a miss in the middle of a run of hits and runs the eight-hit count to its last sample. A filter that did not restart on a miss, or that mapped the count field wrongly, would fire one strobe early or late. It pairs the reset key with rise watching, and it repeats reset events in intermittent mode. A decoder that ignored the direction would reset the system on a rising supply, and a filter that did not re-arm would emit back-to-back pulses. It also measures strobe spacing in all three intervals and after a mode change while running. This exposes a wrong interval table or a mode that is not captured at start.

// File: rtl/svm_pkg.sv
package svm_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_MASK,
        ST_CONT,
        ST_WAIT,
        ST_STROBE
    } svm_state_e;

    // Interval in clock cycles for an intermittent mode; 0 for continuous.
    function automatic int unsigned svm_interval(input logic [1:0] m,
                                                 input int unsigned base_log2);
        int unsigned step;
        if (m == 2'd0) return 0;
        step = {30'd0, m} - 32'd1;
        return 32'd1 << (base_log2 + 2 * step);
    endfunction

    // Number of consecutive hits needed for an event.
    function automatic logic [3:0] svm_need(input logic [1:0] sel);
        return 4'd1 << sel;
    endfunction

endpackage

// File: rtl/svm_tick_timer.sv
module svm_tick_timer #(
    parameter int TW = 13
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic [TW-1:0] limit,
    output logic          tick
);
    logic [TW-1:0] cnt_q, cnt_d;

    assign tick = run && (cnt_q == limit - TW'(1));

    always_comb begin
        if (!run || tick) cnt_d = '0;
        else              cnt_d = cnt_q + TW'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/svm_hit_filter.sv
module svm_hit_filter #(
    parameter int HW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          sample,
    input  logic          hit,
    input  logic [HW-1:0] need,
    output logic          fire
);
    logic [HW-1:0] hits_q, hits_d;

    assign fire = sample && hit && ((hits_q + HW'(1)) == need);

    always_comb begin
        hits_d = hits_q;
        if (clr)
            hits_d = '0;
        else if (sample)
            hits_d = (hit && !fire) ? hits_q + HW'(1) : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) hits_q <= '0;
        else        hits_q <= hits_d;
    end
endmodule

// File: rtl/svm_seq.sv
module svm_seq
    import svm_pkg::*;
#(
    parameter int          MASK_CYC   = 64,
    parameter int          STROBE_CYC = 4,
    parameter int          IV_LOG2    = 8,
    parameter int          HIT_W      = 4,
    parameter logic [3:0]  RESET_KEY  = 4'hA
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       en,
    input  logic [1:0] mode,
    input  logic       dir,
    input  logic [1:0] cnt_sel,
    input  logic [3:0] action,
    input  logic       cmp_out,
    input  logic       flag_clr,
    output logic       cmp_pwr,
    output logic       det_status,
    output logic       irq_flag,
    output logic       rst_req
);
    localparam int PH_MAX = (MASK_CYC > STROBE_CYC) ? MASK_CYC : STROBE_CYC;
    localparam int PH_W   = $clog2(PH_MAX);
    localparam int TW     = IV_LOG2 + 5;

    typedef struct packed {
        svm_state_e      st;
        logic [PH_W-1:0] ph;
        logic [1:0]      mode;
        logic            det;
        logic            irq;
        logic            rst;
    } regs_t;

    regs_t r_q, r_d;

    logic          hit;
    logic          use_reset;
    logic          ev;
    logic          sample;
    logic          fire;
    logic          tick;
    logic [TW-1:0] interval;

    assign hit       = (cmp_out == dir);
    assign use_reset = (action == RESET_KEY) && !dir;
    assign interval  = TW'(svm_interval(r_q.mode, IV_LOG2));

    svm_tick_timer #(.TW(TW)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (r_q.st == ST_WAIT),
        .limit (interval),
        .tick  (tick)
    );

    svm_hit_filter #(.HW(HIT_W)) u_filter (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (!(r_q.st == ST_WAIT || r_q.st == ST_STROBE)),
        .sample (sample),
        .hit    (hit),
        .need   (HIT_W'(svm_need(cnt_sel))),
        .fire   (fire)
    );

    always_comb begin
        r_d     = r_q;
        r_d.rst = 1'b0;
        ev      = 1'b0;
        sample  = 1'b0;
        if (!en) begin
            r_d.st  = ST_IDLE;
            r_d.ph  = '0;
            r_d.det = 1'b0;
        end else begin
            unique case (r_q.st)
                ST_IDLE: begin
                    r_d.st   = ST_MASK;
                    r_d.ph   = '0;
                    r_d.mode = mode;
                end
                ST_MASK: begin
                    if (r_q.ph == PH_W'(MASK_CYC - 1)) begin
                        r_d.ph = '0;
                        r_d.st = (r_q.mode == 2'd0) ? ST_CONT : ST_WAIT;
                    end else begin
                        r_d.ph = r_q.ph + PH_W'(1);
                    end
                end
                ST_CONT: begin
                    r_d.det = hit;
                    ev      = hit && !r_q.det;
                end
                ST_WAIT: begin
                    if (tick) begin
                        r_d.st = ST_STROBE;
                        r_d.ph = '0;
                    end
                end
                ST_STROBE: begin
                    if (r_q.ph == PH_W'(STROBE_CYC - 1)) begin
                        r_d.det = hit;
                        sample  = 1'b1;
                        ev      = fire;
                        r_d.st  = ST_WAIT;
                        r_d.ph  = '0;
                    end else begin
                        r_d.ph = r_q.ph + PH_W'(1);
                    end
                end
                default: r_d.st = ST_IDLE;
            endcase
        end

        if (ev && use_reset)       r_d.rst = 1'b1;
        else if (ev)               r_d.irq = 1'b1;
        else if (flag_clr)         r_d.irq = 1'b0;
        if (ev && use_reset && flag_clr) r_d.irq = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.st   <= ST_IDLE;
            r_q.ph   <= '0;
            r_q.mode <= 2'd0;
            r_q.det  <= 1'b0;
            r_q.irq  <= 1'b0;
            r_q.rst  <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    assign cmp_pwr    = (r_q.st == ST_MASK) || (r_q.st == ST_CONT) || (r_q.st == ST_STROBE);
    assign det_status = r_q.det;
    assign irq_flag   = r_q.irq;
    assign rst_req    = r_q.rst;

endmodule

// File: rtl/svm_seq_chk.sv
module svm_seq_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       en,
    input logic       dir,
    input logic [3:0] action,
    input logic       flag_clr,
    input logic       cmp_pwr,
    input logic       irq_flag,
    input logic       rst_req
);
    // R1: disabled for three samples means fully quiet
    a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (!en && !$past(en) && !$past(en, 2)) |-> (!cmp_pwr && !rst_req));

    // R5: a reset request follows only the key with drop watching
    a_r5_reset_key: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |-> ($past(action) == 4'hA && !$past(dir)));

    // R6: reset request lasts one cycle
    a_r6_rst_single: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |=> !rst_req);

    // R7: flag holds without a clear
    a_r7_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_flag && !flag_clr) |=> irq_flag);

    // R7: a clear while idle empties the flag
    a_r7_flag_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_clr && !en && !$past(en)) |=> !irq_flag);
endmodule

bind svm_seq svm_seq_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .en       (en),
    .dir      (dir),
    .action   (action),
    .flag_clr (flag_clr),
    .cmp_pwr  (cmp_pwr),
    .irq_flag (irq_flag),
    .rst_req  (rst_req)
);

// File: tb/tb_svm_seq.sv
module tb_svm_seq;
    localparam int CLK_PERIOD = 10;
    localparam int NV = 6;
    // {dir, action[3:0], cmp_out, exp_status, exp_irq, exp_rst}
    localparam logic [8:0] VEC [NV] = '{
        {1'b0, 4'h0, 1'b0, 1'b1, 1'b1, 1'b0},
        {1'b0, 4'hA, 1'b0, 1'b1, 1'b0, 1'b1},
        {1'b1, 4'hA, 1'b1, 1'b1, 1'b1, 1'b0},
        {1'b0, 4'h5, 1'b1, 1'b0, 1'b0, 1'b0},
        {1'b1, 4'h0, 1'b0, 1'b0, 1'b0, 1'b0},
        {1'b0, 4'hB, 1'b0, 1'b1, 1'b1, 1'b0}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       en = 1'b0;
    logic [1:0] mode = 2'd0;
    logic       dir = 1'b0;
    logic [1:0] cnt_sel = 2'd0;
    logic [3:0] action = 4'h0;
    logic       cmp_out = 1'b1;
    logic       flag_clr = 1'b0;
    logic       cmp_pwr, det_status, irq_flag, rst_req;

    int checks = 0;
    int fails = 0;
    int cyc = 0;
    int rst_pulses = 0;

    svm_seq dut (
        .clk(clk), .rst_n(rst_n), .en(en), .mode(mode), .dir(dir),
        .cnt_sel(cnt_sel), .action(action), .cmp_out(cmp_out),
        .flag_clr(flag_clr), .cmp_pwr(cmp_pwr), .det_status(det_status),
        .irq_flag(irq_flag), .rst_req(rst_req)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (rst_req) rst_pulses <= rst_pulses + 1;
    end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic start(input logic [1:0] m, input logic d, input logic [3:0] a,
                         input logic [1:0] s, input logic c);
        en = 1'b0;
        tick(3);
        flag_clr = 1'b1;
        tick(1);
        flag_clr = 1'b0;
        mode = m; dir = d; action = a; cnt_sel = s; cmp_out = c;
        tick(1);
        en = 1'b1;
    endtask

    task automatic wait_fall();
        logic prev;
        bit done;
        prev = cmp_pwr;
        done = 1'b0;
        while (!done) begin
            @(negedge clk);
            done = prev && !cmp_pwr;
            prev = cmp_pwr;
        end
    endtask

    task automatic wait_rise(output int c);
        logic prev;
        bit done;
        prev = cmp_pwr;
        done = 1'b0;
        while (!done) begin
            @(negedge clk);
            done = !prev && cmp_pwr;
            prev = cmp_pwr;
        end
        c = cyc;
    endtask

    task automatic period_check(input string req, input int exp_period);
        int c1, c2, hi;
        bit done;
        wait_fall();
        wait_rise(c1);
        hi = 1;
        done = 1'b0;
        while (!done) begin
            @(negedge clk);
            if (cmp_pwr) hi++;
            else done = 1'b1;
        end
        wait_rise(c2);
        chk(req, c2 - c1, exp_period);
        chk("R4 strobe width", hi, 4);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        int base;
        tick(3);
        chk("R1 reset cmp_pwr", cmp_pwr, 0);
        chk("R1 reset det_status", det_status, 0);
        chk("R7 reset irq_flag", irq_flag, 0);
        chk("R6 reset rst_req", rst_req, 0);
        rst_n = 1'b1;
        tick(2);

        // Continuous-mode table (R2, R3, R5)
        for (int i = 0; i < NV; i++) begin
            start(2'd0, VEC[i][8], VEC[i][7:4], 2'd0, VEC[i][3]);
            base = rst_pulses;
            tick(40);
            chk("R2 masked status", det_status, 0);
            chk("R2 masked irq", irq_flag, 0);
            chk("R2 powered in mask", cmp_pwr, 1);
            tick(40);
            chk("R3 status", det_status, VEC[i][2]);
            chk("R5 irq", irq_flag, VEC[i][1]);
            chk("R5 reset pulses", rst_pulses - base, VEC[i][0]);
        end

        // R3 tracking and re-arming, R7 clear, R1 disable
        start(2'd0, 1'b0, 4'h0, 2'd0, 1'b0);
        tick(80);
        chk("R3 hit status", det_status, 1);
        flag_clr = 1'b1; tick(1); flag_clr = 1'b0;
        cmp_out = 1'b1;
        tick(3);
        chk("R3 miss status", det_status, 0);
        chk("R7 cleared", irq_flag, 0);
        tick(300);
        chk("R3 power held", cmp_pwr, 1);
        cmp_out = 1'b0;
        tick(3);
        chk("R3 second hit", det_status, 1);
        chk("R3 second event", irq_flag, 1);
        en = 1'b0;
        tick(3);
        chk("R1 idle power", cmp_pwr, 0);
        chk("R1 idle status", det_status, 0);
        chk("R7 sticky after disable", irq_flag, 1);
        flag_clr = 1'b1; tick(1); flag_clr = 1'b0;
        tick(1);
        chk("R7 clear", irq_flag, 0);

        // R4 intervals
        start(2'd1, 1'b0, 4'h0, 2'd0, 1'b1);
        period_check("R4 mode1 period", 260);
        start(2'd2, 1'b0, 4'h0, 2'd0, 1'b1);
        period_check("R4 mode2 period", 1028);
        start(2'd3, 1'b0, 4'h0, 2'd0, 1'b1);
        period_check("R4 mode3 period", 4100);

        // R9 mode captured at enable
        start(2'd1, 1'b0, 4'h0, 2'd0, 1'b1);
        tick(5);
        mode = 2'd0;
        period_check("R9 captured mode period", 260);

        // R8 single hit
        start(2'd1, 1'b0, 4'h0, 2'd0, 1'b0);
        wait_fall();
        wait_fall();
        chk("R4 sampled status", det_status, 1);
        chk("R8 one hit event", irq_flag, 1);

        // R8 two hits
        start(2'd1, 1'b0, 4'h0, 2'd1, 1'b0);
        wait_fall();
        wait_fall();
        chk("R8 first of two", irq_flag, 0);
        wait_fall();
        chk("R8 second of two", irq_flag, 1);

        // R8 four hits with a miss in the run
        start(2'd1, 1'b0, 4'h0, 2'd2, 1'b0);
        wait_fall();
        for (int k = 1; k <= 8; k++) begin
            wait_fall();
            if (k == 4) chk("R4 miss status", det_status, 0);
            if (k == 7) chk("R8 miss restarts run", irq_flag, 0);
            if (k == 8) chk("R8 four after miss", irq_flag, 1);
            cmp_out = (k == 3) ? 1'b1 : 1'b0;
        end

        // R8 eight hits
        start(2'd1, 1'b0, 4'h0, 2'd3, 1'b0);
        wait_fall();
        for (int k = 1; k <= 8; k++) begin
            wait_fall();
            if (k == 7) chk("R8 seven of eight", irq_flag, 0);
            if (k == 8) chk("R8 eight of eight", irq_flag, 1);
        end

        // R5/R8 repeated reset events re-arm after each
        start(2'd1, 1'b0, 4'hA, 2'd1, 1'b0);
        base = rst_pulses;
        wait_fall();
        for (int k = 0; k < 4; k++) wait_fall();
        tick(2);
        chk("R8 reset re-arm count", rst_pulses - base, 2);
        chk("R5 no irq with key", irq_flag, 0);

        // R5 rise watch with key gives interrupt only
        start(2'd1, 1'b1, 4'hA, 2'd0, 1'b1);
        base = rst_pulses;
        wait_fall();
        wait_fall();
        tick(2);
        chk("R5 rise irq", irq_flag, 1);
        chk("R5 rise no reset", rst_pulses - base, 0);

        en = 1'b0;
        tick(3);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule